// File: doc/BRIEF.md
# Pixel Region Hit Buffer

This block is the digital readout logic of one region of a binary pixel sensor. The region has 42 pixels, organised as 7 groups of 6. Each pixel delivers one comparator hit bit, and a per-pixel mask can silence it. While a bunch train is running, the block samples every group on each bunch-crossing strobe. Each group that holds at least one unmasked hit becomes one record in a local memory. The record holds the group index, the group's 6-bit hit pattern and the 13-bit timestamp of the crossing.

No data leave the block during the train. After `train_end`, the stored records are drained in write order as 30-bit words over a valid/ready handshake. Any records lost to a full memory are flagged. A one-cycle done pulse closes the readout and clears the buffer, so the next train starts empty.

Top module: `pixhb_top`

## Requirements
- R1: Group g covers pixels 6g to 6g+5. Bit b of a record's pattern field is pixel 6g+b, and a group with no unmasked hit writes no record.
- R2: A pixel whose `pix_mask` bit is 1 never appears in any record, even if its `pix_hit` bit is 1.
- R3: The timestamp is 0 at `train_start` and rises by one on each `bx_strobe` within the train. A record carries the value the counter held at the strobe of its own crossing.
- R4: The timestamp saturates at 8191. Every crossing from the 8192nd onward is tagged 8191.
- R5: When several groups hit in one crossing, they are written one per clock in ascending group order, and all of them carry that crossing's timestamp.
- R6: `rd_valid` stays low for the whole train. Readout begins only after `train_end`.
- R7: Output word layout: [29:27] group index, [26:21] pattern, [20:8] timestamp, [7:0] zero.
- R8: The memory holds 64 records. Hits beyond that within a train are dropped, and `ovf_flag` goes high and stays high through the readout.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold. A word is consumed on a cycle where both are high, and words come out in write order.
- R10: After the last word, or at once for a train with no records, `rd_done` pulses for exactly one cycle. `ovf_flag` is then low and the next train starts with an empty memory.
- R11: After reset, `rd_valid`, `rd_done` and `ovf_flag` are low.
- R12: `bx_strobe` outside a train (before `train_start`) writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Pulse: begin acquisition, clear timestamp |
| train_end | input | 1 | Pulse: end acquisition, begin readout |
| bx_strobe | input | 1 | Bunch-crossing strobe (at least 8 clocks apart) |
| pix_hit | input | 42 | Comparator hit bits, pixel p on bit p |
| pix_mask | input | 42 | 1 masks the pixel |
| rd_data | output | 30 | Readout word |
| rd_valid | output | 1 | Readout word available |
| rd_ready | input | 1 | Consumer accepts word |
| rd_done | output | 1 | One-cycle pulse at readout end |
| ovf_flag | output | 1 | Records were dropped in this train |

## Verification
The hardest states to reach are timestamp saturation and memory overflow. Saturation needs more than 8190 strobes within one train, so the stimulus sends a long run of empty crossings at one strobe per two clocks, then places hits just before and just after the limit. Overflow is reached with ten crossings in which all seven groups hit, which makes 70 records for 64 slots. The drain then checks that every one of the 64 stored words holds the expected group and timestamp, and that the flag stays raised until done.

// File: rtl/pixhb_pkg.sv
package pixhb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_DRAIN = 2'd2
  } hb_state_t;
endpackage

// File: rtl/pixhb_tstamp.sv
module pixhb_tstamp #(
  parameter int TS_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  output logic [TS_W-1:0] ts
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  function automatic logic [TS_W-1:0] sat_inc(input logic [TS_W-1:0] v);
    return (v == TS_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ts <= '0;
    else if (clr)  ts <= '0;
    else if (step) ts <= sat_inc(ts);
  end

  // R4: the counter holds at its maximum
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_MAX && step && !clr) |=> (ts == TS_MAX));
endmodule

// File: rtl/pixhb_capture.sv
module pixhb_capture #(
  parameter int NGRP  = 7,
  parameter int GSIZE = 6,
  parameter int GI_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NGRP*GSIZE-1:0] hits_masked,
  output logic                  busy,
  output logic                  wr_en,
  output logic [GI_W-1:0]       wr_grp,
  output logic [GSIZE-1:0]      wr_pat
);
  localparam int NPIX = NGRP * GSIZE;

  logic [NGRP-1:0] grp_any;
  logic [NGRP-1:0] pend;
  logic [NGRP-1:0] grant;
  logic [NPIX-1:0] pat_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_any
    assign grp_any[g] = |hits_masked[g*GSIZE +: GSIZE];
  end

  function automatic logic [GI_W-1:0] low_idx(input logic [NGRP-1:0] v);
    logic [GI_W-1:0] r;
    r = '0;
    for (int i = NGRP - 1; i >= 0; i--) if (v[i]) r = GI_W'(i);
    return r;
  endfunction

  assign grant  = pend & (~pend + 1'b1);
  assign wr_en  = |pend;
  assign busy   = |pend;
  assign wr_grp = low_idx(pend);
  assign wr_pat = pat_q[int'(wr_grp)*GSIZE +: GSIZE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      pat_q <= '0;
    end else if (load) begin
      pend  <= grp_any;
      pat_q <= hits_masked;
    end else begin
      pend  <= pend & ~grant;
    end
  end

  // R5: at most one group is granted per clock
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R1: a written pattern is never empty
  a_r1_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_pat != '0));
endmodule

// File: rtl/pixhb_store.sv
module pixhb_store #(
  parameter int REC_W = 22,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             rd_adv,
  input  logic             clr,
  output logic [REC_W-1:0] rd_rec,
  output logic             rd_avail,
  output logic             ovf
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW:0]      cnt;
  logic [AW:0]      rptr;
  logic             full;
  logic             drop;

  assign full     = (cnt == (AW+1)'(DEPTH));
  assign drop     = wr_en && full;
  assign rd_avail = (rptr != cnt);
  assign rd_rec   = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[cnt[AW-1:0]] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr_en && !full) cnt <= cnt + 1'b1;
      if (drop)           ovf <= 1'b1;
      if (rd_adv)         rptr <= rptr + 1'b1;
    end
  end

  // R8: occupancy is bounded by the depth
  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  // R8: a dropped write raises the flag
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clr) |=> ovf);
  // R8: the flag is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/pixhb_top.sv
module pixhb_top #(
  parameter int NGRP  = 7,
  parameter int GSIZE = 6,
  parameter int TS_W  = 13,
  parameter int DEPTH = 64,
  parameter int OUT_W = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  train_start,
  input  logic                  train_end,
  input  logic                  bx_strobe,
  input  logic [NGRP*GSIZE-1:0] pix_hit,
  input  logic [NGRP*GSIZE-1:0] pix_mask,
  output logic [OUT_W-1:0]      rd_data,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic                  rd_done,
  output logic                  ovf_flag
);
  import pixhb_pkg::*;

  localparam int GI_W  = $clog2(NGRP);
  localparam int REC_W = GI_W + GSIZE + TS_W;
  localparam int PAD_W = OUT_W - REC_W;
  localparam int AW    = $clog2(DEPTH);

  hb_state_t        state;
  logic             end_req;
  logic [TS_W-1:0]  ts_now;
  logic [TS_W-1:0]  ts_q;
  logic             cap_load;
  logic             cap_busy;
  logic             cap_wr;
  logic [GI_W-1:0]  cap_grp;
  logic [GSIZE-1:0] cap_pat;
  logic [REC_W-1:0] st_rec;
  logic             st_avail;
  logic             rd_adv;
  logic             drain_fin;
  logic             train_clr;

  function automatic logic [REC_W-1:0] pack_rec(input logic [GI_W-1:0] g,
                                                input logic [GSIZE-1:0] p,
                                                input logic [TS_W-1:0] t);
    return {g, p, t};
  endfunction

  assign train_clr = (state == ST_IDLE) && train_start;
  assign cap_load  = (state == ST_ACQ) && bx_strobe;
  assign rd_valid  = (state == ST_DRAIN) && st_avail;
  assign rd_adv    = rd_valid && rd_ready;
  assign drain_fin = (state == ST_DRAIN) && !st_avail;
  assign rd_data   = {st_rec, {PAD_W{1'b0}}};

  pixhb_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .clr(train_clr), .step(cap_load), .ts(ts_now)
  );

  pixhb_capture #(.NGRP(NGRP), .GSIZE(GSIZE), .GI_W(GI_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load),
    .hits_masked(pix_hit & ~pix_mask),
    .busy(cap_busy), .wr_en(cap_wr), .wr_grp(cap_grp), .wr_pat(cap_pat)
  );

  pixhb_store #(.REC_W(REC_W), .DEPTH(DEPTH), .AW(AW)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_wr),
    .wr_rec(pack_rec(cap_grp, cap_pat, ts_q)),
    .rd_adv(rd_adv), .clr(drain_fin),
    .rd_rec(st_rec), .rd_avail(st_avail), .ovf(ovf_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      end_req <= 1'b0;
      ts_q    <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= drain_fin;
      if (cap_load) ts_q <= ts_now;
      case (state)
        ST_IDLE: if (train_start) begin
          state   <= ST_ACQ;
          end_req <= 1'b0;
        end
        ST_ACQ: begin
          if (train_end) end_req <= 1'b1;
          if ((end_req || train_end) && !cap_busy && !cap_load) state <= ST_DRAIN;
        end
        ST_DRAIN: if (drain_fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: nothing is written while readout runs
  a_r6_no_write_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |-> !cap_wr);
  // R9: a stalled word holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R10: done is a single-cycle pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  // R10: flag is clear when done is seen
  a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !ovf_flag);
endmodule

// File: tb/pixhb_top_bench.sv
module pixhb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_start = 1'b0, train_end = 1'b0, bx_strobe = 1'b0;
  logic [41:0] pix_hit = '0, pix_mask = '0;
  logic [29:0] rd_data;
  logic        rd_valid, rd_ready = 1'b0, rd_done, ovf_flag;

  int total = 0, bad = 0;
  logic [29:0] got [128];
  int nrec;
  logic ovseen;
  logic fin;

  always #2 clk = ~clk;

  pixhb_top u_pixhb_top (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .bx_strobe(bx_strobe), .pix_hit(pix_hit), .pix_mask(pix_mask),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_done(rd_done), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [41:0] hit;
    logic [41:0] msk;
    logic [1:0]  n;
    logic [29:0] first;
    logic [29:0] last;
  } vec_t;

  // single-crossing trains at timestamp 0 (R1, R2, R7)
  localparam vec_t VECS [5] = '{
    '{42'h1,             42'h0,             2'd1, 30'h0020_0000, 30'h0020_0000},
    '{42'h2000,          42'h0,             2'd1, 30'h1040_0000, 30'h1040_0000},
    '{42'h300_0000_0000, 42'h100_0000_0000, 2'd1, 30'h3400_0000, 30'h3400_0000},
    '{42'h80,            42'h80,            2'd0, 30'h0,         30'h0},
    '{42'h10_0000_0020,  42'h0,             2'd2, 30'h0400_0000, 30'h3020_0000}
  };

  function automatic logic [29:0] mkword(int g, logic [5:0] p, int t);
    return {3'(g), p, 13'(t), 8'h00};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_train();
    @(negedge clk) train_start = 1'b1;
    @(negedge clk) train_start = 1'b0;
  endtask

  task automatic crossing(input logic [41:0] h, input logic [41:0] m, input int gap);
    @(negedge clk) begin pix_hit = h; pix_mask = m; bx_strobe = 1'b1; end
    @(negedge clk) begin bx_strobe = 1'b0; pix_hit = '0; pix_mask = '0; end
    repeat (gap) @(negedge clk);
  endtask

  task automatic end_train();
    @(negedge clk) train_end = 1'b1;
    @(negedge clk) train_end = 1'b0;
  endtask

  task automatic drain();
    nrec = 0; ovseen = 1'b0; fin = 1'b0;
    rd_ready = 1'b1;
    for (int i = 0; i < 3000 && !fin; i++) begin
      if (rd_done) fin = 1'b1;
      else begin
        if (rd_valid) begin
          if (nrec < 128) got[nrec] = rd_data;
          nrec++;
          ovseen |= ovf_flag;
        end
        @(negedge clk);
      end
    end
    chk(fin, "R10 done pulse seen", 32'(fin), 32'd1);
    @(negedge clk);
    chk(!rd_done, "R10 done lasts one cycle", 32'(rd_done), 32'd0);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [29:0] d0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !rd_done && !ovf_flag, "R11 reset outputs",
        {29'd0, rd_valid, rd_done, ovf_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: strobe outside a train, then an empty train
    crossing(42'h3FF_FFFF_FFFF, 42'h0, 4);
    chk(!rd_valid, "R12 idle strobe gives no output", 32'(rd_valid), 32'd0);
    start_train();
    end_train();
    drain();
    chk(nrec == 0, "R12 R10 empty train count", 32'(nrec), 32'd0);

    // table walk
    for (int v = 0; v < 5; v++) begin
      start_train();
      crossing(VECS[v].hit, VECS[v].msk, 8);
      chk(!rd_valid, "R6 no valid in train", 32'(rd_valid), 32'd0);
      end_train();
      drain();
      chk(nrec == int'(VECS[v].n), "R1 R2 record count", 32'(nrec), 32'(VECS[v].n));
      if (VECS[v].n != 0) begin
        chk(got[0] == VECS[v].first, "R7 R1 first word", 32'(got[0]), 32'(VECS[v].first));
        chk(got[nrec-1] == VECS[v].last, "R5 R2 last word", 32'(got[nrec-1]), 32'(VECS[v].last));
      end
    end

    // R3: timestamps across crossings
    start_train();
    crossing(42'h40, 42'h0, 8);
    crossing(42'h0, 42'h0, 8);
    crossing(42'h0, 42'h0, 8);
    crossing(42'h1_0000_0000, 42'h0, 8);
    end_train();
    drain();
    chk(nrec == 2, "R3 count", 32'(nrec), 32'd2);
    chk(got[0] == mkword(1, 6'h01, 0), "R3 ts 0", 32'(got[0]), 32'(mkword(1, 6'h01, 0)));
    chk(got[1] == mkword(5, 6'h04, 3), "R3 ts 3", 32'(got[1]), 32'(mkword(5, 6'h04, 3)));

    // R5: all groups in one crossing, R9 stall
    start_train();
    crossing(42'h0, 42'h0, 2);
    crossing(42'h3FF_FFFF_FFFF, 42'h0, 10);
    end_train();
    repeat (4) @(negedge clk);
    d0 = rd_data;
    chk(rd_valid, "R9 valid while stalled", 32'(rd_valid), 32'd1);
    @(negedge clk);
    chk(rd_valid && rd_data == d0, "R9 data held", 32'(rd_data), 32'(d0));
    drain();
    chk(nrec == 7, "R5 seven records", 32'(nrec), 32'd7);
    for (int k = 0; k < 7 && k < nrec; k++)
      chk(got[k] == mkword(k, 6'h3F, 1), "R5 ascending order same ts",
          32'(got[k]), 32'(mkword(k, 6'h3F, 1)));

    // R8: overflow
    start_train();
    for (int c = 0; c < 10; c++) crossing(42'h3FF_FFFF_FFFF, 42'h0, 9);
    chk(!rd_valid, "R6 no valid during long train", 32'(rd_valid), 32'd0);
    end_train();
    drain();
    chk(nrec == 64, "R8 capacity", 32'(nrec), 32'd64);
    chk(ovseen, "R8 overflow flag in readout", 32'(ovseen), 32'd1);
    begin
      int errs = 0;
      for (int k = 0; k < 64 && k < nrec; k++)
        if (got[k] != mkword(k % 7, 6'h3F, k / 7)) errs++;
      chk(errs == 0, "R8 R9 stored words in order", 32'(errs), 32'd0);
    end
    chk(!ovf_flag, "R10 flag cleared", 32'(ovf_flag), 32'd0);

    // R10: next train starts empty
    start_train();
    crossing(42'h2, 42'h0, 8);
    end_train();
    drain();
    chk(nrec == 1 && !ovseen, "R10 fresh train", 32'(nrec), 32'd1);

    // R4: saturation
    start_train();
    for (int c = 0; c < 8190; c++) crossing(42'h0, 42'h0, 0);
    crossing(42'h1, 42'h0, 8);
    for (int c = 0; c < 5; c++) crossing(42'h0, 42'h0, 0);
    crossing(42'h1, 42'h0, 8);
    end_train();
    drain();
    chk(nrec == 2, "R4 count", 32'(nrec), 32'd2);
    chk(got[0] == mkword(0, 6'h01, 8190), "R4 ts 8190", 32'(got[0]), 32'(mkword(0, 6'h01, 8190)));
    chk(got[1] == mkword(0, 6'h01, 8191), "R4 saturated ts", 32'(got[1]), 32'(mkword(0, 6'h01, 8191)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule